// File: doc/BRIEF.md
# Two-Wire Byte Memory Slave with Range Write Lock

This block is the target side of a two-wire serial bus (clock line plus open-drain data line) in front of a byte-wide storage array of 2^ADDR_W locations. The default is 13 address bits, which gives 8192 bytes. A bus master selects the block by its own 7-bit device identity. It then either sends a two-byte location followed by data bytes to store, or reads bytes starting at the retained location. A single pointer serves both directions and advances after every byte. Stores finish inside the bus transfer, so the master never has to poll for completion.

A two-bit lock setting locks none of the array, its lowest quarter, its lowest half or all of it. It is held in a small configuration register that is loaded through a plain strobe and cleared by reset. A data byte aimed at a locked location is neither stored nor acknowledged. Traffic addressed to any other device identity, such as a companion timekeeping device on the same wires, is ignored completely. That traffic leaves the pointer where it was, so a later current-location read continues where the last memory access stopped.

The bus lines are sampled on the system clock, which must run well above the bus bit rate. The data line is driven only low, through `sda_oe`. There is no streaming interface: every pin is a plain level or strobe.

Top module: `mem2w_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and the lock setting is 00, so every location accepts writes.
- R2: An address byte whose upper seven bits equal DEV_ID (default 7'h50) is acknowledged. An address byte carrying any other identity is not acknowledged, and the rest of that transfer leaves the array and the pointer unchanged.
- R3: In a write transfer the block acknowledges two location bytes, high byte first. Only the low ADDR_W-8 bits of the high byte are used; its upper bits are ignored.
- R4: Each data byte of a write transfer to an unlocked location is stored and acknowledged in its own ninth clock, and the next byte can follow at once.
- R5: The pointer advances by one after every data byte, stored, refused or read, and wraps from the last location (1FFFh by default) to 0.
- R6: A read transfer returns data from the current pointer. A location write followed by a repeated START and a read transfer therefore reads from the new location, and a read without a preceding location write continues from the retained pointer.
- R7: Lock setting 00 locks nothing, 01 locks the lowest quarter (0000h–07FFh), 10 locks the lowest half (0000h–0FFFh) and 11 locks the whole array. A data byte for a locked location is not acknowledged and leaves the stored value unchanged.
- R8: Read data goes out most significant bit first. A master acknowledge (data low in the ninth clock) makes the block send the next byte. A master non-acknowledge makes it release the line until the next START or STOP.
- R9: `sda_oe` changes only while the clock line is low, so the block never creates a START or STOP condition.
- R10: A one-cycle `cfg_we` pulse loads `cfg_wp` into the lock setting, and the setting holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus bit rate |
| rst_n | input | 1 | Active-low synchronous reset; clears the lock setting |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| cfg_we | input | 1 | Load strobe for the lock setting |
| cfg_wp | input | 2 | New lock setting: 00 none, 01 low quarter, 10 low half, 11 all |

## Verification
A corrupted bit counter or state shows up at the ports within one byte time. The ninth-clock acknowledge lands on the wrong clock, or the data line is driven during a master bit. A pointer that is wrong or that moved during a foreign-identity transfer stays hidden until the next read: the first byte returned then comes from the wrong location. A wrong lock compare shows up in the acknowledge of the very byte it affects, and a later read-back confirms whether the stored value changed. The bench compares each acknowledge and each read byte against its own model of the memory, and it watches the data-line drive on every clock.

// File: rtl/mem2w_pkg.sv
package mem2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVID,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD,
    ST_SKIP
  } bus_st_e;

  localparam logic [3:0] BI_PRE = 4'hF;
endpackage

// File: rtl/mem2w_bus_cond.sv
module mem2w_bus_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_in};
      sda_p <= {sda_p[STAGES-2:0], sda_in};
      scl_d <= scl_lvl;
      sda_d <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_p[STAGES-1];
  assign sda_lvl   = sda_p[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/mem2w_wp_guard.sv
module mem2w_wp_guard #(
  parameter int ADDR_W = 13
) (
  input  logic [1:0]        wp,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  always_comb begin
    unique case (wp)
      2'b00:   locked = 1'b0;
      2'b01:   locked = (addr[ADDR_W-1:ADDR_W-2] == 2'b00);
      2'b10:   locked = ~addr[ADDR_W-1];
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/mem2w_byte_store.sv
module mem2w_byte_store #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/mem2w_slave.sv
module mem2w_slave #(
  parameter int          ADDR_W = 13,
  parameter logic [6:0]  DEV_ID = 7'h50,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic       cfg_we,
  input  logic [1:0] cfg_wp
);
  import mem2w_pkg::*;

  localparam int HI_W = ADDR_W - 8;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  bus_st_e st;
  logic [3:0] bit_idx;
  logic [7:0] shreg;
  logic [6:0] txreg;
  logic [ADDR_W-1:0] ptr;
  logic [HI_W-1:0] hi_hold;
  logic rd_req, mack;
  logic [1:0] wp;
  logic locked, mem_we, byte_done;
  logic [7:0] rdata;

  mem2w_bus_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  mem2w_wp_guard #(.ADDR_W(ADDR_W)) u_guard (
    .wp(wp), .addr(ptr), .locked(locked)
  );

  mem2w_byte_store #(.ADDR_W(ADDR_W), .DATA_W(8)) u_store (
    .clk(clk), .we(mem_we), .addr(ptr), .wdata(shreg), .rdata(rdata)
  );

  assign byte_done = scl_fall && (bit_idx == 4'd7) && (st != ST_IDLE);
  assign mem_we    = byte_done && (st == ST_WR) && !locked;

  // lock setting register
  always_ff @(posedge clk) begin
    if (!rst_n)      wp <= 2'b00;
    else if (cfg_we) wp <= cfg_wp;
  end

  // bit capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      mack  <= 1'b0;
    end else if (scl_rise && st != ST_IDLE) begin
      if (bit_idx < 4'd8 && st != ST_RD) shreg <= {shreg[6:0], sda_lvl};
      if (bit_idx == 4'd8 && st == ST_RD) mack <= ~sda_lvl;
    end
  end

  // bus sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_idx <= BI_PRE;
      sda_oe  <= 1'b0;
      ptr     <= '0;
      hi_hold <= '0;
      txreg   <= '0;
      rd_req  <= 1'b0;
    end else if (stop_evt) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      st      <= ST_DEVID;
      bit_idx <= BI_PRE;
      sda_oe  <= 1'b0;
    end else if (scl_fall && st != ST_IDLE) begin
      if (bit_idx == BI_PRE) begin
        bit_idx <= 4'd0;
      end else if (bit_idx < 4'd7) begin
        bit_idx <= bit_idx + 4'd1;
        if (st == ST_RD) sda_oe <= ~txreg[3'd6 - bit_idx[2:0]];
      end else if (bit_idx == 4'd7) begin
        bit_idx <= 4'd8;
        unique case (st)
          ST_DEVID: begin
            if (shreg[7:1] == DEV_ID) begin
              sda_oe <= 1'b1;
              rd_req <= shreg[0];
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_SKIP;
            end
          end
          ST_AHI: begin
            sda_oe  <= 1'b1;
            hi_hold <= shreg[HI_W-1:0];
          end
          ST_ALO: begin
            sda_oe <= 1'b1;
            ptr    <= {hi_hold, shreg};
          end
          ST_WR: begin
            sda_oe <= !locked;
            ptr    <= ptr + 1'b1;
          end
          ST_RD: begin
            sda_oe <= 1'b0;
            ptr    <= ptr + 1'b1;
          end
          default: sda_oe <= 1'b0;
        endcase
      end else begin
        bit_idx <= 4'd0;
        sda_oe  <= 1'b0;
        unique case (st)
          ST_DEVID: begin
            if (rd_req) begin
              st     <= ST_RD;
              txreg  <= rdata[6:0];
              sda_oe <= ~rdata[7];
            end else begin
              st <= ST_AHI;
            end
          end
          ST_AHI: st <= ST_ALO;
          ST_ALO: st <= ST_WR;
          ST_RD: begin
            if (mack) begin
              txreg  <= rdata[6:0];
              sda_oe <= ~rdata[7];
            end else begin
              st <= ST_SKIP;
            end
          end
          default: st <= st;
        endcase
      end
    end
  end
endmodule

// File: rtl/mem2w_slave_chk.sv
module mem2w_slave_chk #(
  parameter int ADDR_W = 13
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sda_oe,
  input logic                  scl_lvl,
  input logic                  scl_fall,
  input mem2w_pkg::bus_st_e    st,
  input logic [ADDR_W-1:0]     ptr,
  input logic [1:0]            wp,
  input logic                  cfg_we,
  input logic                  mem_we
);
  import mem2w_pkg::*;

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  p_ptr_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> $past(scl_fall));

  p_full_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wp != 2'b11));

  p_quarter_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wp == 2'b01) |-> (ptr[ADDR_W-1:ADDR_W-2] != 2'b00));

  p_half_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wp == 2'b10) |-> ptr[ADDR_W-1]);

  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);

  p_wp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wp) |-> $past(cfg_we));
endmodule

bind mem2w_slave mem2w_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_lvl(scl_lvl),
  .scl_fall(scl_fall), .st(st), .ptr(ptr), .wp(wp), .cfg_we(cfg_we),
  .mem_we(mem_we)
);

// File: tb/mem2w_slave_test.sv
module mem2w_slave_test;
  localparam int Q = 6;
  localparam int DEPTH = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_wp = 2'b00;
  logic sda_oe;
  wire  bus_sda = sda_m & ~sda_oe;

  int n_checks = 0;
  int n_fail = 0;
  int oe_glitch = 0;
  bit done = 1'b0;

  logic [7:0] ref_mem [DEPTH];
  int ref_ptr = 0;
  logic [1:0] ref_wp = 2'b00;

  always #2.5 clk = ~clk;

  mem2w_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(bus_sda),
    .sda_oe(sda_oe), .cfg_we(cfg_we), .cfg_wp(cfg_wp)
  );

  // per-clock monitor: data drive may move only while clock line is low (R9)
  logic prev_oe = 1'b0;
  logic prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl_m && prev_scl) oe_glitch++;
    prev_oe  = sda_oe;
    prev_scl = scl_m;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit locked_at(input int p, input logic [1:0] w);
    case (w)
      2'b00:   return 1'b0;
      2'b01:   return p < DEPTH / 4;
      2'b10:   return p < DEPTH / 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic put_bit(input logic b, output logic s);
    sda_m = b;
    waitq();
    scl_m = 1'b1;
    waitq();
    s = bus_sda;
    waitq();
    scl_m = 1'b0;
    waitq();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(v[i], s);
    put_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] v);
    logic s;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      put_bit(1'b1, s);
      v = {v[6:0], s};
    end
    put_bit(!give_ack, s);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic send_loc(input int a, input logic [7:0] hi_extra);
    logic ack;
    put_byte({7'h50, 1'b0}, ack);
    check(ack, "R2 own id write ack", ack, 1);
    put_byte(8'((a >> 8) & 8'h1F) | hi_extra, ack);
    check(ack, "R3 high location ack", ack, 1);
    put_byte(8'(a & 8'hFF), ack);
    check(ack, "R3 low location ack", ack, 1);
    ref_ptr = a % DEPTH;
  endtask

  task automatic write_run(input int a, input logic [7:0] hi_extra, input int n, input logic [7:0] seed);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_loc(a, hi_extra);
    for (int i = 0; i < n; i++) begin
      d = seed + 8'(i);
      put_byte(d, ack);
      if (locked_at(ref_ptr, ref_wp))
        check(!ack, "R7 locked byte not acked", ack, 0);
      else begin
        check(ack, "R4 data byte acked", ack, 1);
        ref_mem[ref_ptr] = d;
      end
      ref_ptr = (ref_ptr + 1) % DEPTH;
    end
    bus_stop();
  endtask

  task automatic read_run(input bit random, input int a, input int n, input string req);
    logic ack;
    logic [7:0] v;
    bus_start();
    if (random) begin
      send_loc(a, 8'h00);
      bus_start();
    end
    put_byte({7'h50, 1'b1}, ack);
    check(ack, "R2 own id read ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, v);
      check(v === ref_mem[ref_ptr], req, v, ref_mem[ref_ptr]);
      ref_ptr = (ref_ptr + 1) % DEPTH;
    end
    check(sda_oe === 1'b0, "R8 released after master nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic set_lock(input logic [1:0] v);
    @(negedge clk);
    cfg_wp = v;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    ref_wp = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-R actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sda_oe === 1'b0, "R1 reset release", sda_oe, 0);

    // R4, R6, R8: plain write then random and current reads
    write_run(32'h0100, 8'h00, 6, 8'h10);
    read_run(1'b1, 32'h0100, 4, "R6 R8 random read data");
    read_run(1'b0, 0, 2, "R6 current read data");

    // R5 wrap across the last location
    write_run(32'h1FFE, 8'h00, 3, 8'hA0);
    check(ref_ptr == 1, "R5 model wrap", ref_ptr, 1);
    read_run(1'b1, 32'h1FFE, 3, "R5 wrapped read data");

    // R3 upper high-byte bits ignored
    write_run(32'h0200, 8'hE0, 2, 8'h55);
    read_run(1'b1, 32'h0200, 2, "R3 upper bits ignored");

    // prefill boundary regions, unlocked
    write_run(32'h07FE, 8'h00, 4, 8'h30);
    write_run(32'h0FFE, 8'h00, 4, 8'h40);
    write_run(32'h1FF0, 8'h00, 1, 8'h50);

    // R7 R10 lock ranges
    set_lock(2'b01);
    write_run(32'h07FE, 8'h00, 4, 8'hC0);
    read_run(1'b1, 32'h07FE, 4, "R7 R10 quarter lock content");
    set_lock(2'b10);
    write_run(32'h0FFE, 8'h00, 4, 8'hD0);
    read_run(1'b1, 32'h0FFE, 4, "R7 R10 half lock content");
    set_lock(2'b11);
    write_run(32'h1FF0, 8'h00, 1, 8'hE0);
    read_run(1'b1, 32'h1FF0, 1, "R7 full lock content");

    // R2 foreign identity leaves the pointer alone
    read_run(1'b1, 32'h0101, 1, "R2 setup read");
    bus_start();
    put_byte({7'h68, 1'b0}, ack);
    check(!ack, "R2 foreign id not acked", ack, 0);
    put_byte(8'h00, ack);
    check(!ack, "R2 foreign byte not acked", ack, 0);
    put_byte(8'h00, ack);
    bus_stop();
    read_run(1'b0, 0, 2, "R2 pointer kept over foreign id");

    // R1 reset clears the lock setting
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ref_wp = 2'b00;
    repeat (3) @(negedge clk);
    write_run(32'h0000, 8'h00, 2, 8'h77);
    read_run(1'b1, 32'h0000, 2, "R1 unlocked after reset");

    check(oe_glitch == 0, "R9 drive moved with clock high", oe_glitch, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule